// File: doc/BRIEF.md
# Eight-Channel DMA Request Arbiter

This block decides which channel of an eight-channel DMA engine may move data next. Software programs it through a small register port. A global register carries a master enable, two sticky fault flags (one for a non-maskable interrupt and one for an address error), an operating-mode bit and a channel-count bit. Each channel has a control word (enable, end flag, request source) and a transfer counter. Each channel takes its request from one of three places: a request that is always raised, an external request line, or a request line from an on-chip peripheral.

On every clock the block works out which channels are eligible and issues at most one grant, with channel 0 first and channel 7 last. A granted channel keeps its grant until the data path answers with `xfer_done` or the channel stops being eligible. Each acknowledged grant counts the channel's counter down by one. When the counter reaches zero, the channel's end flag is set and the channel stops until software clears the flag. The operating mode sets which channels are active and which of them accept external request lines. Either global fault flag, or a cleared master enable, stops every channel at once.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset the global register, every channel control word and every counter read as 0, `grant` is 0 and `end_flags` is 0.
- R2: A channel is eligible only when all of these hold: its enable bit (control bit 0) is 1, the master enable (global bit 0) is 1, its end flag (control bit 1) is 0, the interrupt flag (global bit 1) is 0, the address-error flag (global bit 2) is 0, its counter is nonzero, and its selected source is requesting. Only an eligible channel is granted.
- R3: Writing the master enable to 0 removes any grant within two clocks, and no channel is granted while it stays 0. Setting it back to 1 resumes arbitration.
- R4: In normal mode (global bit 4 = 0) all eight channels are active, and the external request lines count only for channels 0 and 1.
- R5: In alternate mode (global bit 4 = 1) with the channel-count bit (global bit 3) at 0, external lines count for channels 0 to 3 and channels 4 to 7 are never granted, whatever their source.
- R6: In alternate mode with the channel-count bit at 1, all eight channels are active and external lines count for channels 0 to 7.
- R7: The request source is control bits 3:2. 00 requests at all times, 01 follows `ext_req[i]` (subject to R4 to R6), 10 follows `periph_req[i]`, and 11 never requests.
- R8: `grant` is one-hot or zero. When it is zero and several channels are eligible, the lowest-numbered eligible channel is granted on the next clock.
- R9: A grant is held, even when a higher-priority channel becomes eligible, until `xfer_done` is sampled high or the holder becomes ineligible. After `xfer_done`, `grant` is 0 for one clock before the next arbitration.
- R10: Each `xfer_done` while a channel is granted decrements that channel's counter (register 16+i). The step from 1 to 0 sets the channel's end flag, which blocks the channel. Writing control bit 1 as 0 clears the flag, and writing it as 1 leaves the flag unchanged.
- R11: A high `nmi_in` sets the interrupt flag. The flag clears only when the global register is read while the flag is 1 and then written with bit 1 at 0. A write of 0 with no such read before it leaves the flag set.
- R12: A high `aerr_in` sets the address-error flag, which clears by the same read-1-then-write-0 sequence on global bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr | input | 5 | Register address: 0 global, 8+i control, 16+i counter |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational, 0 when no read |
| ext_req | input | 8 | External request lines, one per channel |
| periph_req | input | 8 | On-chip peripheral request lines, one per channel |
| nmi_in | input | 1 | Sets the interrupt flag |
| aerr_in | input | 1 | Sets the address-error flag |
| xfer_done | input | 1 | Data path acknowledges the current grant |
| grant | output | 8 | One-hot grant, bit i for channel i |
| end_flags | output | 8 | Per-channel end flags |

## Verification
The assertions assume that `xfer_done` is raised only while a grant is visible, that a register read and a register write never fall in the same clock, and that software never loads a counter in the same clock as an acknowledgement to that channel. The bench drives every input on the falling edge. It pulses `xfer_done` only after it has seen the expected grant, and it issues reads and writes from separate tasks that each take their own clock. Counters are loaded only while the channel is disabled or idle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CH_N      = 8;
  localparam int ADDR_W    = 5;
  localparam int CTRL_BASE = 8;
  localparam int CNT_BASE  = 16;

  // global register bit positions
  localparam int GB_ME   = 0;
  localparam int GB_NMI  = 1;
  localparam int GB_AERR = 2;
  localparam int GB_WIDE = 3;
  localparam int GB_ALT  = 4;

  typedef enum logic [1:0] {
    SRC_AUTO   = 2'b00,
    SRC_EXT    = 2'b01,
    SRC_PERIPH = 2'b10,
    SRC_NONE   = 2'b11
  } req_src_e;

  // channels whose external request line is honoured
  function automatic logic [CH_N-1:0] ext_accept_mask(input logic alt, input logic wide);
    logic [CH_N-1:0] m;
    m = '0;
    for (int i = 0; i < CH_N; i++) begin
      if (!alt)      m[i] = (i < 2);
      else if (wide) m[i] = 1'b1;
      else           m[i] = (i < 4);
    end
    return m;
  endfunction

  // channels that may be granted at all
  function automatic logic [CH_N-1:0] active_mask(input logic alt, input logic wide);
    logic [CH_N-1:0] m;
    for (int i = 0; i < CH_N; i++) m[i] = !(alt && !wide) || (i < 4);
    return m;
  endfunction

  // lowest set bit as one-hot
  function automatic logic [CH_N-1:0] first_one(input logic [CH_N-1:0] v);
    logic [CH_N-1:0] r;
    r = '0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/dma_arb_glob.sv
module dma_arb_glob (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_glob,
  input  logic       rd_glob,
  input  logic [4:0] wdata,
  input  logic       nmi_in,
  input  logic       aerr_in,
  output logic       me,
  output logic       nmif,
  output logic       aef,
  output logic       wide,
  output logic       alt
);
  import dma_arb_pkg::*;

  logic nmi_arm, aef_arm;
  logic clr_nmi, clr_aef;

  // named clear events: a write of 0 after a read of 1
  assign clr_nmi = wr_glob && nmi_arm && !wdata[GB_NMI];
  assign clr_aef = wr_glob && aef_arm && !wdata[GB_AERR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      me      <= 1'b0;
      wide    <= 1'b0;
      alt     <= 1'b0;
      nmif    <= 1'b0;
      aef     <= 1'b0;
      nmi_arm <= 1'b0;
      aef_arm <= 1'b0;
    end else begin
      if (wr_glob) begin
        me   <= wdata[GB_ME];
        wide <= wdata[GB_WIDE];
        alt  <= wdata[GB_ALT];
      end
      if (nmi_in)       nmif <= 1'b1;
      else if (clr_nmi) nmif <= 1'b0;
      if (aerr_in)      aef  <= 1'b1;
      else if (clr_aef) aef  <= 1'b0;
      if (wr_glob)               nmi_arm <= 1'b0;
      else if (rd_glob && nmif)  nmi_arm <= 1'b1;
      if (wr_glob)               aef_arm <= 1'b0;
      else if (rd_glob && aef)   aef_arm <= 1'b1;
    end
  end

  AST_NMI_NO_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (nmif && !wr_glob) |=> nmif); // R11
  AST_NMI_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (nmif && !nmi_arm) |=> nmif); // R11
  AST_AERR_NO_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (aef && !wr_glob) |=> aef); // R12
  AST_AERR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (aef && !aef_arm) |=> aef); // R12
endmodule

// File: rtl/dma_arb_chan.sv
module dma_arb_chan #(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ctrl,
  input  logic [3:0]            ctrl_wdata,
  input  logic                  wr_cnt,
  input  logic [CNT_W-1:0]      cnt_wdata,
  input  logic                  ack,
  output logic                  en,
  output logic                  te,
  output dma_arb_pkg::req_src_e src,
  output logic [CNT_W-1:0]      cnt,
  output logic                  cnt_zero
);
  import dma_arb_pkg::*;

  function automatic logic hits_end(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - CNT_W'(1);
  endfunction

  logic end_evt;
  assign end_evt  = ack && hits_end(cnt);
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= 1'b0;
      te  <= 1'b0;
      src <= SRC_AUTO;
      cnt <= '0;
    end else begin
      if (wr_ctrl) begin
        en  <= ctrl_wdata[0];
        src <= req_src_e'(ctrl_wdata[3:2]);
      end
      if (end_evt)                      te <= 1'b1;
      else if (wr_ctrl && !ctrl_wdata[1]) te <= 1'b0;
      if (wr_cnt)   cnt <= cnt_wdata;
      else if (ack) cnt <= count_down(cnt);
    end
  end

  AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_cnt && cnt == CNT_W'(1)) |=> (te && cnt == '0)); // R10
  AST_ACK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_cnt && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R10
  AST_FLAG_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (te && wr_ctrl && ctrl_wdata[1]) |=> te); // R10
endmodule

// File: rtl/dma_arb_grant.sv
module dma_arb_grant (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [dma_arb_pkg::CH_N-1:0] elig,
  input  logic                       done,
  output logic [dma_arb_pkg::CH_N-1:0] gnt
);
  import dma_arb_pkg::*;

  logic [CH_N-1:0] gnt_d;
  logic            holder_ok;
  logic            busy;

  assign busy      = (gnt != '0);
  assign holder_ok = ((gnt & elig) != '0);

  always_comb begin
    if (busy && done)   gnt_d = '0;
    else if (holder_ok) gnt_d = gnt;
    else                gnt_d = first_one(elig);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gnt <= '0;
    else        gnt <= gnt_d;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8
  AST_GRANT_WAS_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((gnt & $past(elig)) != '0)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && holder_ok) |=> (gnt == $past(gnt))); // R9
  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy); // R9
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [7:0]        ext_req,
  input  logic [7:0]        periph_req,
  input  logic              nmi_in,
  input  logic              aerr_in,
  input  logic              xfer_done,
  output logic [7:0]        grant,
  output logic [7:0]        end_flags
);
  import dma_arb_pkg::*;

  localparam logic [ADDR_W-1:0] A_GLOB = '0;

  logic me, nmif, aef, wide, alt;
  logic [CH_N-1:0] ch_en, ch_te, ch_zero, ch_req, ch_elig, ch_ack, src_ext;
  logic [CH_N-1:0] wr_ctrl, wr_cnt, ext_ok, active;
  req_src_e        ch_src [CH_N];
  logic [CNT_W-1:0] ch_cnt [CH_N];
  logic            run_ok;
  logic            wr_glob, rd_glob;

  assign wr_glob = reg_wr && (reg_addr == A_GLOB);
  assign rd_glob = reg_rd && (reg_addr == A_GLOB);

  dma_arb_glob u_glob (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_glob (wr_glob),
    .rd_glob (rd_glob),
    .wdata   (reg_wdata[4:0]),
    .nmi_in  (nmi_in),
    .aerr_in (aerr_in),
    .me      (me),
    .nmif    (nmif),
    .aef     (aef),
    .wide    (wide),
    .alt     (alt)
  );

  assign ext_ok = ext_accept_mask(alt, wide);
  assign active = active_mask(alt, wide);
  assign run_ok = me && !nmif && !aef;

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_BASE + i);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_BASE + i);

    assign wr_ctrl[i] = reg_wr && (reg_addr == A_CTRL);
    assign wr_cnt[i]  = reg_wr && (reg_addr == A_CNT);
    assign ch_ack[i]  = xfer_done && grant[i];

    dma_arb_chan #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (wr_ctrl[i]),
      .ctrl_wdata (reg_wdata[3:0]),
      .wr_cnt     (wr_cnt[i]),
      .cnt_wdata  (reg_wdata[CNT_W-1:0]),
      .ack        (ch_ack[i]),
      .en         (ch_en[i]),
      .te         (ch_te[i]),
      .src        (ch_src[i]),
      .cnt        (ch_cnt[i]),
      .cnt_zero   (ch_zero[i])
    );

    always_comb begin
      src_ext[i] = (ch_src[i] == SRC_EXT);
      unique case (ch_src[i])
        SRC_AUTO:   ch_req[i] = 1'b1;
        SRC_EXT:    ch_req[i] = ext_req[i] && ext_ok[i];
        SRC_PERIPH: ch_req[i] = periph_req[i];
        default:    ch_req[i] = 1'b0;
      endcase
    end

    assign ch_elig[i] = run_ok && ch_en[i] && !ch_te[i] && !ch_zero[i]
                        && active[i] && ch_req[i];

    AST_END_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ch_te[i] |-> !grant[i]); // R10

    if (i >= 2) begin : g_ext_hi
      AST_EXT_NORMAL_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[i] && $past(src_ext[i])) |-> $past(alt)); // R4
    end
    if (i >= 4) begin : g_ext_top
      AST_EXT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[i] && $past(src_ext[i])) |-> $past(wide)); // R5
    end
  end

  dma_arb_grant u_grant (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (ch_elig),
    .done  (xfer_done),
    .gnt   (grant)
  );

  assign end_flags = ch_te;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == A_GLOB) begin
        reg_rdata[GB_ME]   = me;
        reg_rdata[GB_NMI]  = nmif;
        reg_rdata[GB_AERR] = aef;
        reg_rdata[GB_WIDE] = wide;
        reg_rdata[GB_ALT]  = alt;
      end
      for (int i = 0; i < CH_N; i++) begin
        if (reg_addr == ADDR_W'(CTRL_BASE + i))
          reg_rdata[3:0] = {ch_src[i], ch_te[i], ch_en[i]};
        if (reg_addr == ADDR_W'(CNT_BASE + i))
          reg_rdata = DATA_W'(ch_cnt[i]);
      end
    end
  end

  AST_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    !me |=> (grant == '0)); // R3
  AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (nmif || aef) |=> (grant == '0)); // R2
  AST_NARROW_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (alt && !wide) |=> (grant[CH_N-1:4] == '0)); // R5
endmodule

// File: tb/dma_req_arbiter_tb_top.sv
module dma_req_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  ext_req = '0, periph_req = '0;
  logic        nmi_in = 1'b0, aerr_in = 1'b0, xfer_done = 1'b0;
  logic [7:0]  grant, end_flags;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_req_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_req(ext_req), .periph_req(periph_req), .nmi_in(nmi_in),
    .aerr_in(aerr_in), .xfer_done(xfer_done), .grant(grant),
    .end_flags(end_flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 5'(a);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // global write keeping flag bits at 1 (a 1 never clears them)
  task automatic glob(input bit me, input bit wide, input bit alt);
    wr(0, (int'(alt) << 4) | (int'(wide) << 3) | 6 | int'(me));
  endtask

  task automatic ctrl(input int ch, input int src, input bit en);
    wr(8 + ch, (src << 2) | int'(en));
  endtask

  task automatic ack;
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic clear_all;
    glob(0, 0, 0);
    for (int c = 0; c < 8; c++) ctrl(c, 0, 0);
    for (int c = 0; c < 8; c++) wr(16 + c, 10);
    ext_req = '0; periph_req = '0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 grant after reset", grant, 8'h00);
    check("R1 end flags after reset", end_flags, 8'h00);
    rd(0, d);  check("R1 global reg", d, 16'h0);
    rd(11, d); check("R1 ctrl reg ch3", d, 16'h0);
    rd(21, d); check("R1 count ch5", d, 16'h0);
  endtask

  task automatic t_eligible;
    clear_all;
    ctrl(3, 0, 1);
    settle(3); check("R2 no grant without master enable", grant, 8'h00);
    glob(1, 0, 0);
    settle(2); check("R2 auto channel granted", grant, 8'h08);
    ctrl(3, 0, 0);
    settle(2); check("R2 disabled channel dropped", grant, 8'h00);
    wr(19, 0); ctrl(3, 0, 1);
    settle(3); check("R2 zero count not granted", grant, 8'h00);
  endtask

  task automatic t_priority;
    clear_all;
    ctrl(5, 0, 1); ctrl(1, 0, 1);
    glob(1, 0, 0);
    settle(2); check("R8 lowest index wins", grant, 8'h02);
    ack;
    check("R9 gap after done", grant, 8'h00);
    settle(1); check("R8 rearbitrates to ch1", grant, 8'h02);
    ctrl(1, 0, 0);
    settle(2); check("R8 next channel ch5", grant, 8'h20);
  endtask

  task automatic t_hold;
    logic [15:0] d;
    // ch5 holds from previous task
    ctrl(2, 0, 1);
    settle(3); check("R9 no preemption by ch2", grant, 8'h20);
    ack;
    settle(1); check("R9 ch2 after done", grant, 8'h04);
    rd(21, d); check("R10 ch5 counter stepped", d, 16'd9);
  endtask

  task automatic t_suspend;
    glob(0, 0, 0);
    settle(1); check("R3 suspend drops grant", grant, 8'h00);
    settle(3); check("R3 stays suspended", grant, 8'h00);
    glob(1, 0, 0);
    settle(2); check("R3 resume", grant, 8'h04);
  endtask

  task automatic t_count_end;
    logic [15:0] d;
    clear_all;
    wr(16, 2); ctrl(0, 0, 1); glob(1, 0, 0);
    settle(2); check("R10 ch0 granted", grant, 8'h01);
    ack; settle(1);
    check("R10 regrant with count 1", grant, 8'h01);
    ack; settle(2);
    check("R10 end flag set", end_flags, 8'h01);
    check("R10 blocked after end", grant, 8'h00);
    rd(16, d); check("R10 counter zero", d, 16'h0);
    wr(8, 3); settle(2);
    check("R10 writing 1 keeps flag", end_flags, 8'h01);
    wr(16, 1); ctrl(0, 0, 1); settle(2);
    check("R10 flag cleared by 0", end_flags, 8'h00);
    check("R10 regrant after clear", grant, 8'h01);
  endtask

  task automatic t_ext_normal;
    clear_all;
    ext_req = 8'hFF;
    for (int c = 0; c < 8; c++) ctrl(c, 1, 1);
    glob(1, 0, 0);
    settle(2); check("R4 ext ch0 in normal", grant, 8'h01);
    ctrl(0, 1, 0);
    settle(2); check("R4 ext ch1 in normal", grant, 8'h02);
    ctrl(1, 1, 0);
    settle(3); check("R4 ext ignored ch2-7", grant, 8'h00);
    ctrl(6, 0, 1);
    settle(2); check("R4 ch6 active via auto", grant, 8'h40);
    ctrl(6, 1, 1);
  endtask

  task automatic t_alt;
    glob(1, 0, 1);
    settle(2); check("R5 ext ch2 in narrow alt", grant, 8'h04);
    ctrl(2, 1, 0); ctrl(3, 1, 0); ctrl(5, 0, 1);
    settle(3); check("R5 ch4-7 idle in narrow alt", grant, 8'h00);
    glob(1, 1, 1);
    settle(2); check("R6 ext ch4 in wide alt", grant, 8'h10);
    ctrl(4, 1, 0); ctrl(5, 1, 1);
    settle(2); check("R6 ext ch5 in wide alt", grant, 8'h20);
  endtask

  task automatic t_sources;
    clear_all;
    ctrl(2, 3, 1); ctrl(3, 2, 1); glob(1, 0, 0);
    settle(3); check("R7 periph low and none give no grant", grant, 8'h00);
    periph_req = 8'h08;
    settle(2); check("R7 periph request granted", grant, 8'h08);
    periph_req = 8'h00;
    settle(2); check("R7 periph drop ends grant", grant, 8'h00);
  endtask

  task automatic t_flags;
    logic [15:0] d;
    clear_all;
    ctrl(0, 0, 1); glob(1, 0, 0);
    settle(2); check("R11 baseline grant", grant, 8'h01);
    @(negedge clk); nmi_in = 1'b1; @(negedge clk); nmi_in = 1'b0;
    settle(1); check("R11 nmi stops grant", grant, 8'h00);
    wr(0, 1);
    rd(0, d); check("R11 write 0 without read keeps flag", 32'(d[1]), 1);
    wr(0, 1);
    rd(0, d); check("R11 read then write 0 clears", 32'(d[1]), 0);
    settle(1); check("R11 grant resumes", grant, 8'h01);
    @(negedge clk); aerr_in = 1'b1; @(negedge clk); aerr_in = 1'b0;
    settle(1); check("R12 address error stops grant", grant, 8'h00);
    wr(0, 1);
    rd(0, d); check("R12 write 0 without read keeps flag", 32'(d[2]), 1);
    wr(0, 1);
    rd(0, d); check("R12 read then write 0 clears", 32'(d[2]), 0);
    settle(1); check("R12 grant resumes", grant, 8'h01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_eligible;
    t_priority;
    t_hold;
    t_suspend;
    t_count_end;
    t_ext_normal;
    t_alt;
    t_sources;
    t_flags;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule